// File: doc/BRIEF.md
# De-interleaver SRAM access sequencer

This block sits between the de-interleaver's metric store logic and an external asynchronous static RAM. It takes one request at a time (address, write flag and write byte), turns it into a timed pattern of chip-enable, output-enable and write-enable on the memory pins, and returns a single-cycle acknowledge. A read returns its byte with that acknowledge. The access time of the memory is 80 ns, so each strobe is held low for a parameter-set number of system clocks (eight at the default 100 MHz clock). One setup cycle comes before each strobe and one hold cycle comes after it.

Two capacity settings are supported. A 256 KB store serves full decoding capacity and a 128 KB store serves half capacity. The top address bit leaves the block in both true and inverted form, so two 128 KB devices can be used as banks with no decoder between them. In half capacity the top bit is held low. The data path is either one 8-bit device, or two 4-bit devices that share the low four data lines and have their own chip enables. In the second case each byte costs two back-to-back memory cycles.

Top module: `dlv_sram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip enables, output enable and write enable are all high (inactive), the data drive enable is low and the acknowledge is low.
- R2: A request seen while idle is accepted at the next clock edge. Exactly one acknowledge cycle follows, P*(SETUP_CYC+STROBE_CYC+HOLD_CYC) edges after acceptance, where P is 1 in byte mode and 2 in split mode. The acknowledge is high for one cycle only.
- R3: Every read or write strobe stays low for exactly STROBE_CYC clock cycles.
- R4: During a write the data drive enable is high from the setup cycle before the write strobe falls until the hold cycle after it rises. It is low during reads and while idle.
- R5: The write byte is held on the data lines at the rising edge of the write strobe, so a later read of the same location returns it.
- R6: Read data is captured at the rising edge of the output-enable strobe and returned on rdata_o together with the acknowledge.
- R7: The inverted top address output is always the complement of the true top address output.
- R8: With full_cap_i high at request time, the top address output follows address bit 17, so the two banks are distinct. With it low, the top output is forced low, and addresses differing only in bit 17 alias.
- R9: In split mode, the low-nibble device (sram_ce_no[0] low, sram_ce_no[1] high) is accessed first with byte bits 3:0 on data lines 3:0. The high-nibble device (sram_ce_no[1] low) is accessed second with byte bits 7:4 on data lines 3:0. In byte mode both enables are low together and all eight lines carry the byte.
- R10: The address outputs remain constant for the whole of an access, including both phases of a split access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_cap_i | input | 1 | 1: 256 KB store, 0: 128 KB store (sampled with the request) |
| split_bus_i | input | 1 | 1: two 4-bit devices, 0: one 8-bit device (sampled with the request) |
| req_i | input | 1 | Access request, level |
| we_i | input | 1 | 1: write, 0: read |
| addr_i | input | 18 | Byte address |
| wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid with ack_o |
| sram_addr_o | output | 17 | Memory address bits 16:0 |
| sram_a17_o | output | 1 | Top address bit, true |
| sram_a17_n_o | output | 1 | Top address bit, inverted |
| sram_ce_no | output | 2 | Chip enables, active low; bit 0 low nibble device, bit 1 high nibble device |
| sram_oe_no | output | 1 | Output enable / read strobe, active low |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_dq_o | output | 8 | Data toward memory |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o; low means tri-stated |
| sram_dq_i | input | 8 | Data from memory |

## Verification
The bench measures every strobe's low width and the acknowledge latency in both bus modes. A sequencer with an off-by-one counter shows up as a seven- or nine-cycle strobe or as a shifted acknowledge. Writes are modelled only at the rising edge of write enable, so data that is dropped before that edge, or not driven before the fall, corrupts the read-back that follows. The bench also feeds a filler value on the data lines while output enable is high, so a capture taken at the wrong edge returns that filler. Half-capacity aliasing, full-capacity bank separation and the nibble order are swept over many addresses. A swapped nibble order or an unmasked top bit then gives the wrong read data.

// File: rtl/dlv_sram_pkg.sv
package dlv_sram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_HOLD  = 2'd3
  } acc_state_e;
endpackage

// File: rtl/dlv_sram_seq.sv
module dlv_sram_seq
  import dlv_sram_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 8,
  parameter int HOLD_CYC   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic split_i,
  output logic busy_o,
  output logic strobe_o,
  output logic capture_o,
  output logic phase_o,
  output logic split_o,
  output logic done_o
);
  localparam int MAX_CYC = (STROBE_CYC > SETUP_CYC) ?
                           ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC) :
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
  localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  acc_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic phase_q, split_q, done_q;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      split_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          split_q <= split_i;
          phase_q <= 1'b0;
          state_q <= ST_SETUP;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
        end
        ST_SETUP: if (cnt_zero) begin
          state_q <= ST_STRB;
          cnt_q   <= CNT_W'(STROBE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_STRB: if (cnt_zero) begin
          state_q <= ST_HOLD;
          cnt_q   <= CNT_W'(HOLD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_HOLD: if (cnt_zero) begin
          if (split_q && !phase_q) begin
            phase_q <= 1'b1;
            state_q <= ST_SETUP;
            cnt_q   <= CNT_W'(SETUP_CYC - 1);
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign strobe_o  = (state_q == ST_STRB);
  // strobe deasserts after this edge: capture coincides with strobe rise
  assign capture_o = strobe_o && cnt_zero;
  assign phase_o   = phase_q;
  assign split_o   = split_q;
  assign done_o    = done_q;

  // R2: ack is a single-cycle pulse
  a_r2_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2: completion returns the sequencer to idle
  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9: second phase only follows a split first phase
  a_r9_phase_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o) |-> split_o);
endmodule

// File: rtl/dlv_sram_addr.sv
module dlv_sram_addr #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              full_cap_i,
  output logic [ADDR_W-2:0] sram_addr_o,
  output logic              a_top_o,
  output logic              a_top_n_o
);
  logic [ADDR_W-2:0] low_q;
  logic              top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      top_q <= 1'b0;
    end else if (load_i) begin
      low_q <= addr_i[ADDR_W-2:0];
      top_q <= full_cap_i & addr_i[ADDR_W-1];  // half capacity pins bank 0
    end
  end

  assign sram_addr_o = low_q;
  assign a_top_o     = top_q;
  assign a_top_n_o   = ~top_q;
endmodule

// File: rtl/dlv_sram_dpath.sv
module dlv_sram_dpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              split_i,
  input  logic              phase_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              we_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NIB_W  = DATA_W / 2;
  localparam int N_HALF = 2;

  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load_i) begin
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_q[h*NIB_W +: NIB_W] <= '0;
      else if (capture_i && !we_q && (!split_i || (phase_i == h[0])))
        rdata_q[h*NIB_W +: NIB_W] <= split_i ? dq_i[NIB_W-1:0]
                                             : dq_i[h*NIB_W +: NIB_W];
    end
  end

  always_comb begin
    if (split_i) begin
      dq_o = '0;
      dq_o[NIB_W-1:0] = phase_i ? wdata_q[DATA_W-1:NIB_W] : wdata_q[NIB_W-1:0];
    end else begin
      dq_o = wdata_q;
    end
  end

  assign we_o    = we_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/dlv_sram_ctrl.sv
module dlv_sram_ctrl #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 8,   // >= ceil(80 ns / clock period)
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_cap_i,
  input  logic              split_bus_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-2:0] sram_addr_o,
  output logic              sram_a17_o,
  output logic              sram_a17_n_o,
  output logic [1:0]        sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  logic start, busy, strobe, capture, phase, split_q, done, we_q;

  assign start = req_i && !busy && !done;

  dlv_sram_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .split_i  (split_bus_i),
    .busy_o   (busy),
    .strobe_o (strobe),
    .capture_o(capture),
    .phase_o  (phase),
    .split_o  (split_q),
    .done_o   (done)
  );

  dlv_sram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .addr_i     (addr_i),
    .full_cap_i (full_cap_i),
    .sram_addr_o(sram_addr_o),
    .a_top_o    (sram_a17_o),
    .a_top_n_o  (sram_a17_n_o)
  );

  dlv_sram_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .split_i  (split_q),
    .phase_i  (phase),
    .capture_i(capture),
    .dq_i     (sram_dq_i),
    .we_o     (we_q),
    .dq_o     (sram_dq_o),
    .rdata_o  (rdata_o)
  );

  always_comb begin
    if (!busy)        sram_ce_no = 2'b11;
    else if (split_q) sram_ce_no = phase ? 2'b01 : 2'b10;
    else              sram_ce_no = 2'b00;
  end

  assign sram_oe_no   = !(strobe && !we_q);
  assign sram_we_no   = !(strobe && we_q);
  assign sram_dq_oe_o = busy && we_q;
  assign ack_o        = done;

  // R1: no strobe or drive outside an access
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_ce_no == 2'b11) |-> (sram_oe_no && sram_we_no && !sram_dq_oe_o));
  // R4: data already driven in the cycle before the write strobe falls
  a_r4_drive_before_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> (sram_dq_oe_o && $past(sram_dq_oe_o)));
  // R4: data still driven after the write strobe rises
  a_r4_drive_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);
  // R3: read and write strobes never overlap
  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_oe_no || sram_we_no);
  // R10: address frozen while an access is running
  a_r10_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(sram_addr_o) && $stable(sram_a17_o)));
  // R9: exactly one nibble device enabled in split mode
  a_r9_one_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && split_q) |-> ($countones(sram_ce_no) == 1));
endmodule

// File: tb/dlv_sram_ctrl_tb.sv
module dlv_sram_ctrl_tb;
  localparam int SETUP_CYC = 1, STROBE_CYC = 8, HOLD_CYC = 1;
  localparam int PHASE_CYC = SETUP_CYC + STROBE_CYC + HOLD_CYC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic full_cap = 1'b1, split_bus = 1'b0, req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0] wdata = '0, dq_in = 8'hA5;
  logic ack, a17, a17_n, oe_n, we_n, dq_oe;
  logic [7:0] rdata, dq_out;
  logic [16:0] saddr;
  logic [1:0] ce_n;

  int errors = 0, checks = 0;
  logic [7:0] mem8 [int];
  logic [3:0] nib0 [int];
  logic [3:0] nib1 [int];

  always #5 clk = ~clk;

  dlv_sram_ctrl #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .full_cap_i(full_cap), .split_bus_i(split_bus),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .sram_addr_o(saddr), .sram_a17_o(a17), .sram_a17_n_o(a17_n), .sram_ce_no(ce_n),
    .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_dq_o(dq_out), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_in));

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  // memory model and pin monitor, sampled on falling edges
  logic prev_we_n = 1'b1, prev_dq_oe = 1'b0;
  logic [1:0] prev_ce = 2'b11;
  logic [17:0] acc_addr = '0;
  logic [17:0] cur_addr = '0;
  logic cur_full = 1'b1, cur_split = 1'b0, cur_we = 1'b0;
  int low_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int key;
      key = int'({a17, saddr});
      chk(a17_n == ~a17, "R7", a17_n, ~a17);
      if (ce_n == 2'b11) begin
        chk(oe_n && we_n && !dq_oe, "R1", {oe_n, we_n, dq_oe}, 3'b110);
      end else begin
        if (prev_ce == 2'b11) begin
          acc_addr = {a17, saddr};
          chk(ce_n == (cur_split ? 2'b10 : 2'b00), "R9", ce_n, cur_split ? 2'b10 : 2'b00);
          chk(a17 == (cur_full & cur_addr[17]), "R8", a17, cur_full & cur_addr[17]);
        end else begin
          chk({a17, saddr} == acc_addr, "R10", {a17, saddr}, acc_addr);
        end
        chk(dq_oe == cur_we, "R4", dq_oe, cur_we);
      end
      if (!oe_n || !we_n) low_cnt++;
      else if (low_cnt != 0) begin
        chk(low_cnt == STROBE_CYC, "R3", low_cnt, STROBE_CYC);
        low_cnt = 0;
      end
      if (!prev_we_n && we_n) begin
        chk(dq_oe, "R4", dq_oe, 1);
        case (ce_n)
          2'b00: mem8[key] = dq_out;
          2'b10: nib0[key] = dq_out[3:0];
          2'b01: nib1[key] = dq_out[3:0];
          default: chk(1'b0, "R9", ce_n, 0);
        endcase
      end
      if (prev_we_n && !we_n) chk(prev_dq_oe, "R4", prev_dq_oe, 1);
      if (!oe_n) begin
        case (ce_n)
          2'b00: dq_in = mem8.exists(key) ? mem8[key] : 8'h00;
          2'b10: dq_in = {4'h5, nib0.exists(key) ? nib0[key] : 4'h0};
          2'b01: dq_in = {4'h5, nib1.exists(key) ? nib1[key] : 4'h0};
          default: dq_in = 8'hA5;
        endcase
      end else dq_in = 8'hA5;
      prev_we_n = we_n;
      prev_dq_oe = dq_oe;
      prev_ce = ce_n;
    end
  end

  task automatic access(input bit w, input logic [17:0] a, input logic [7:0] d,
                        input bit full, input bit split, output logic [7:0] rd);
    int cnt = 0;
    int exp_lat;
    @(negedge clk);
    cur_addr = a; cur_full = full; cur_split = split; cur_we = w;
    we = w; addr = a; wdata = d; full_cap = full; split_bus = split; req = 1'b1;
    while (!ack && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    exp_lat = (split ? 2 : 1) * PHASE_CYC + 1;
    chk(cnt == exp_lat, "R2", cnt, exp_lat);
    rd = rdata;
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R2", ack, 0);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk(ce_n == 2'b11 && oe_n && we_n && !dq_oe && !ack, "R1",
        {ce_n, oe_n, we_n, dq_oe, ack}, 6'b111100);
    rst_n = 1'b1;
    // byte mode, full capacity: both banks distinct
    for (int i = 0; i < 32; i++)
      access(1, {i[0], 12'h3C0, i[4:0]}, pat(i), 1, 0, rd);
    for (int i = 0; i < 32; i++) begin
      access(0, {i[0], 12'h3C0, i[4:0]}, 8'h00, 1, 0, rd);
      chk(rd == pat(i), "R5", rd, pat(i));
      chk(rd == pat(i), "R8", rd, pat(i));
    end
    // half capacity: bit 17 ignored, aliases onto bank 0
    for (int i = 0; i < 16; i++)
      access(1, {1'b1, 12'h155, i[4:0]}, pat(i + 100), 0, 0, rd);
    for (int i = 0; i < 16; i++) begin
      access(0, {1'b0, 12'h155, i[4:0]}, 8'h00, 0, 0, rd);
      chk(rd == pat(i + 100), "R8", rd, pat(i + 100));
    end
    // split bus: two nibble devices, low first
    for (int i = 0; i < 24; i++)
      access(1, {i[1], 12'h0A0, i[4:0]}, pat(i + 200), 1, 1, rd);
    for (int i = 0; i < 24; i++) begin
      access(0, {i[1], 12'h0A0, i[4:0]}, 8'h00, 1, 1, rd);
      chk(rd == pat(i + 200), "R9", rd, pat(i + 200));
      chk(rd == pat(i + 200), "R6", rd, pat(i + 200));
    end
    // split write seen by nibble model as separate halves
    access(1, 18'h00123, 8'hC3, 1, 1, rd);
    chk(nib0.exists(32'h123) && nib0[32'h123] == 4'h3, "R9", nib0[32'h123], 4'h3);
    chk(nib1.exists(32'h123) && nib1[32'h123] == 4'hC, "R9", nib1[32'h123], 4'hC);
    // read of untouched byte location returns model zero, not bus filler
    access(0, 18'h3FFFF, 8'h00, 1, 0, rd);
    chk(rd == 8'h00, "R6", rd, 8'h00);
    repeat (3) @(negedge clk);
    chk(ce_n == 2'b11 && !dq_oe && !ack, "R1", {ce_n, dq_oe, ack}, 4'b1100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule